// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset or NMI Action

This block is an 8-bit up-counting watchdog. It advances on a clock-enable tick that comes from a prescaler outside the block. Software sets a control register to choose watchdog or interval-timer mode. It also chooses what an overflow does. One choice is a pair of reset pulses: a long internal one and a shorter active-low one for the board. The other choice is a single-cycle non-maskable interrupt request. Software keeps the count from overflowing by writing zero to the counter register.

A source flag records what caused the last reset. A watchdog reset clears the flag and a reset from the external pin sets it. When both happen in the same cycle, the pin wins. While the internal reset pulse is active, the block holds its own control register and counter at their defaults.

Top module: `wdog_rst_nmi`

## Requirements
- R1: While `pin_rst` is high at a clock edge, the next cycle shows `ctrl_o` = 0x00, `count_o` = 0x00, `int_rst_o` = 0, `ext_rst_n_o` = 1, `nmi_o` = 0 and `src_flag_o` = 1.
- R2: `count_o` increments by one on a clock edge with `tick_i` high only if control bit 5 (enable) and control bit 6 (watchdog mode) are both 1. From 0xFF it wraps to 0x00, and that wrap is an overflow.
- R3: `ctrl_o` shows the overflow flag in bit 7, the mode in bit 6, the enable in bit 5 and the action select in bit 4, with bits 3..0 reading 0. An overflow sets the flag. A control write (`wr_sel`=0) with bit 7 at 0 clears the flag, but only if `rd_ctrl_i` saw the flag at 1 after the previous control write. Otherwise the flag is left unchanged.
- R4: An overflow with bit 4 = 1 drives `int_rst_o` high for exactly 518 cycles, starting in the cycle after the overflow edge.
- R5: The same overflow drives `ext_rst_n_o` low for exactly 132 cycles, starting in the same cycle as `int_rst_o`.
- R6: An overflow with bit 4 = 0 drives `nmi_o` high for exactly one cycle. `int_rst_o` stays 0 and `ext_rst_n_o` stays 1.
- R7: During every cycle that `int_rst_o` is high, register writes and ticks are ignored. From the following cycle, `ctrl_o` and `count_o` read 0x00.
- R8: A watchdog reset sets `src_flag_o` to 0. If `pin_rst` is high in the same cycle as an overflow that would start a reset, the flag ends at 1 and no pulse starts.
- R9: A counter write (`wr_en`=1, `wr_sel`=1) in the same cycle as a tick loads the written value. No increment and no overflow take place.
- R10: `pin_rst` during a watchdog reset pulse ends both pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst | input | 1 | External reset pin, synchronous, active high |
| tick_i | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = counter |
| wr_data | input | 8 | Write data |
| rd_ctrl_i | input | 1 | Marks a software read of the control register |
| ctrl_o | output | 8 | Control/status register value |
| count_o | output | 8 | Counter value |
| int_rst_o | output | 1 | Internal reset pulse, active high |
| ext_rst_n_o | output | 1 | External reset output, active low |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |
| src_flag_o | output | 1 | Reset source: 1 = pin, 0 = watchdog |

## Verification
The hardest case to reach is a pin reset that lands in the same cycle as a reset-producing overflow. The source flag only shows which one won if it was 0 beforehand. So the stimulus first runs one full watchdog reset to clear the flag. It then loads the counter with 0xFF and raises the tick and `pin_rst` together on one edge. A counter write arriving together with a tick at 0xFF is set up in the same direct way. A cycle-accurate behavioural model tracks every output through both cases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OVF_B  = 7;
  localparam int MODE_B = 6;
  localparam int EN_B   = 5;
  localparam int SEL_B  = 4;

  typedef struct packed {
    logic ovf;
    logic mode;
    logic en;
    logic sel;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick_i,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_ctrl_i,
  output wdog_ctrl_t       ctl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt_o
);
  logic run;
  logic cnt_wr;
  logic ctl_wr;
  logic arm_q;

  assign run    = ctl_q.en & ctl_q.mode;
  assign cnt_wr = wr_en & wr_sel;
  assign ctl_wr = wr_en & ~wr_sel;

  // a counter write this cycle suppresses the wrap
  assign ovf_evt_o = run & tick_i & (&cnt_q) & ~cnt_wr & ~hold;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
      ctl_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (cnt_wr)
        cnt_q <= wr_data;
      else if (run && tick_i)
        cnt_q <= cnt_q + 1'b1;

      if (ctl_wr) begin
        ctl_q.mode <= wr_data[MODE_B];
        ctl_q.en   <= wr_data[EN_B];
        ctl_q.sel  <= wr_data[SEL_B];
      end

      if (ovf_evt_o)
        ctl_q.ovf <= 1'b1;
      else if (ctl_wr && arm_q && !wr_data[OVF_B])
        ctl_q.ovf <= 1'b0;

      if (ctl_wr)
        arm_q <= 1'b0;
      else if (rd_ctrl_i && ctl_q.ovf)
        arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN     = 518,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LAST = LW'(LEN - 1);

  logic          act_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      left_q <= LAST;
    end else if (act_q) begin
      if (left_q == '0)
        act_q <= 1'b0;
      else
        left_q <= left_q - 1'b1;
    end
  end

  generate
    if (ACT_LOW) begin : g_low
      logic out_q;
      always_ff @(posedge clk) begin
        if (rst)                       out_q <= 1'b1;
        else if (start)                out_q <= 1'b0;
        else if (act_q && left_q == '0) out_q <= 1'b1;
      end
      assign pulse_o = out_q;
    end else begin : g_high
      assign pulse_o = act_q;
    end
  endgenerate
endmodule

// File: rtl/wdog_src_flag.sv
module wdog_src_flag (
  input  logic clk,
  input  logic rst,
  input  logic wdog_evt,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b1;
    else if (wdog_evt)
      flag_q <= 1'b0;
  end
endmodule

// File: rtl/wdog_rst_nmi.sv
module wdog_rst_nmi
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int INT_LEN = 518,
  parameter int EXT_LEN = 132
) (
  input  logic             clk,
  input  logic             pin_rst,
  input  logic             tick_i,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_ctrl_i,
  output logic [CNT_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             int_rst_o,
  output logic             ext_rst_n_o,
  output logic             nmi_o,
  output logic             src_flag_o
);
  wdog_ctrl_t ctl;
  logic       ovf_evt;
  logic       rst_evt;
  logic       nmi_q;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (pin_rst),
    .hold      (int_rst_o),
    .tick_i    (tick_i),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_ctrl_i (rd_ctrl_i),
    .ctl_q     (ctl),
    .cnt_q     (count_o),
    .ovf_evt_o (ovf_evt)
  );

  assign rst_evt = ovf_evt & ctl.sel;

  wdog_pulse #(.LEN(INT_LEN), .ACT_LOW(1'b0)) u_int_pulse (
    .clk     (clk),
    .rst     (pin_rst),
    .start   (rst_evt),
    .pulse_o (int_rst_o)
  );

  wdog_pulse #(.LEN(EXT_LEN), .ACT_LOW(1'b1)) u_ext_pulse (
    .clk     (clk),
    .rst     (pin_rst),
    .start   (rst_evt),
    .pulse_o (ext_rst_n_o)
  );

  wdog_src_flag u_src (
    .clk      (clk),
    .rst      (pin_rst),
    .wdog_evt (rst_evt),
    .flag_q   (src_flag_o)
  );

  always_ff @(posedge clk) begin
    if (pin_rst || int_rst_o)
      nmi_q <= 1'b0;
    else
      nmi_q <= ovf_evt & ~ctl.sel;
  end
  assign nmi_o = nmi_q;

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[OVF_B]  = ctl.ovf;
    ctrl_o[MODE_B] = ctl.mode;
    ctrl_o[EN_B]   = ctl.en;
    ctrl_o[SEL_B]  = ctl.sel;
  end
endmodule

// File: rtl/wdog_rst_nmi_chk.sv
module wdog_rst_nmi_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             pin_rst,
  input logic [CNT_W-1:0] ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             int_rst_o,
  input logic             ext_rst_n_o,
  input logic             nmi_o,
  input logic             src_flag_o
);
  // R1
  pin_rst_src_chk: assert property (@(posedge clk) pin_rst |=> src_flag_o && !int_rst_o && ext_rst_n_o);
  // R5
  ext_within_int_chk: assert property (@(posedge clk) disable iff (pin_rst) !ext_rst_n_o |-> int_rst_o);
  // R5
  ext_starts_with_int_chk: assert property (@(posedge clk) disable iff (pin_rst) $rose(int_rst_o) |-> $fell(ext_rst_n_o));
  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (pin_rst) nmi_o |=> !nmi_o);
  // R6
  nmi_no_reset_chk: assert property (@(posedge clk) disable iff (pin_rst) nmi_o |-> !int_rst_o && ext_rst_n_o);
  // R7
  hold_regs_chk: assert property (@(posedge clk) disable iff (pin_rst) int_rst_o |=> ctrl_o == '0 && count_o == '0);
  // R8
  src_clear_chk: assert property (@(posedge clk) disable iff (pin_rst) $rose(int_rst_o) |-> !src_flag_o);
endmodule

bind wdog_rst_nmi wdog_rst_nmi_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .pin_rst     (pin_rst),
  .ctrl_o      (ctrl_o),
  .count_o     (count_o),
  .int_rst_o   (int_rst_o),
  .ext_rst_n_o (ext_rst_n_o),
  .nmi_o       (nmi_o),
  .src_flag_o  (src_flag_o)
);

// File: tb/test_wdog_rst_nmi.sv
module test_wdog_rst_nmi;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       pin_rst, tick_i, wr_en, wr_sel, rd_ctrl_i;
  logic [7:0] wr_data;
  logic [7:0] ctrl_o, count_o;
  logic       int_rst_o, ext_rst_n_o, nmi_o, src_flag_o;

  wdog_rst_nmi i_wdog_rst_nmi (
    .clk(clk), .pin_rst(pin_rst), .tick_i(tick_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_ctrl_i(rd_ctrl_i), .ctrl_o(ctrl_o), .count_o(count_o),
    .int_rst_o(int_rst_o), .ext_rst_n_o(ext_rst_n_o), .nmi_o(nmi_o), .src_flag_o(src_flag_o)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  bit m_ovf, m_mode, m_en, m_sel, m_arm, m_nmi, m_src;
  int m_cnt, m_int_left, m_ext_left;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (pin_rst) begin
      m_ovf = 0; m_mode = 0; m_en = 0; m_sel = 0; m_arm = 0; m_nmi = 0;
      m_cnt = 0; m_int_left = 0; m_ext_left = 0; m_src = 1;
    end else if (m_int_left > 0) begin
      m_ovf = 0; m_mode = 0; m_en = 0; m_sel = 0; m_arm = 0; m_nmi = 0; m_cnt = 0;
      m_int_left--;
      if (m_ext_left > 0) m_ext_left--;
    end else begin
      bit running, cwr, kwr, ovf_ev, sel_now;
      running = m_en && m_mode;
      cwr = wr_en && wr_sel;
      kwr = wr_en && !wr_sel;
      ovf_ev = running && tick_i && m_cnt == 255 && !cwr;
      sel_now = m_sel;
      m_nmi = ovf_ev && !sel_now;
      if (cwr) m_cnt = wr_data;
      else if (running && tick_i) m_cnt = (m_cnt + 1) % 256;
      if (ovf_ev) m_ovf = 1;
      else if (kwr && m_arm && !wr_data[7]) m_ovf = 0;
      if (kwr) m_arm = 0;
      else if (rd_ctrl_i && ctrl_o[7]) m_arm = 1;
      if (kwr) begin m_mode = wr_data[6]; m_en = wr_data[5]; m_sel = wr_data[4]; end
      if (ovf_ev && sel_now) begin m_int_left = 518; m_ext_left = 132; m_src = 0; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 ctrl", ctrl_o, {m_ovf, m_mode, m_en, m_sel, 4'b0});
      chk("R2 count", count_o, m_cnt);
      chk("R4 int_rst", int_rst_o, m_int_left > 0);
      chk("R5 ext_rst_n", ext_rst_n_o, !(m_ext_left > 0));
      chk("R6 nmi", nmi_o, m_nmi);
      chk("R8 src", src_flag_o, m_src);
    end
  end

  task automatic drive(bit r, bit t, bit we, bit sel, logic [7:0] d, bit rd);
    pin_rst = r; tick_i = t; wr_en = we; wr_sel = sel; wr_data = d; rd_ctrl_i = rd;
    @(negedge clk);
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 8'h00, 0); endtask
  task automatic wctl(logic [7:0] d); drive(0, 0, 1, 0, d, 0); endtask
  task automatic wcnt(logic [7:0] d); drive(0, 0, 1, 1, d, 0); endtask
  task automatic tick(); drive(0, 1, 0, 0, 8'h00, 0); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    int n_int, n_ext;
    pin_rst = 1; tick_i = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_ctrl_i = 0;
    @(negedge clk); @(negedge clk);
    cmp_on = 1'b1;
    drive(1, 0, 0, 0, 8'h00, 0);
    idle();
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 8'h00); chk("R1 count", count_o, 8'h00);
    chk("R1 int", int_rst_o, 0); chk("R1 ext", ext_rst_n_o, 1); chk("R1 src", src_flag_o, 1);

    // R2 enable alone or mode alone does not count
    wctl(8'h20); repeat (5) tick(); chk("R2 en only", count_o, 8'h00);
    wctl(8'h40); repeat (5) tick(); chk("R2 mode only", count_o, 8'h00);

    // R6 NMI path
    wctl(8'h60); repeat (3) tick(); chk("R2 counting", count_o, 8'h03);
    wcnt(8'hFE); tick(); chk("R2 at FF", count_o, 8'hFF);
    tick();
    chk("R6 nmi pulse", nmi_o, 1); chk("R2 wrap", count_o, 8'h00);
    chk("R3 flag set", ctrl_o, 8'hE0); chk("R6 ext high", ext_rst_n_o, 1);
    idle(); chk("R6 nmi one cycle", nmi_o, 0);

    // R3 flag clear protocol
    wctl(8'h60); chk("R3 clear without read", ctrl_o, 8'hE0);
    drive(0, 0, 0, 0, 8'h00, 1); wctl(8'h60); chk("R3 clear after read", ctrl_o, 8'h60);

    // R9 write beats tick at FF
    wcnt(8'hFF); drive(0, 1, 1, 1, 8'h10, 0);
    chk("R9 write wins", count_o, 8'h10); chk("R9 no overflow", nmi_o, 0);
    chk("R9 flag clear", ctrl_o, 8'h60);

    // R4 R5 R7 R8 watchdog reset
    wctl(8'h70); wcnt(8'hFF); tick();
    chk("R4 int starts", int_rst_o, 1); chk("R5 ext starts", ext_rst_n_o, 0);
    chk("R8 src cleared", src_flag_o, 0); chk("R3 flag with sel", ctrl_o, 8'hF0);
    n_int = 1; n_ext = 1;
    drive(0, 1, 1, 0, 8'h70, 0);
    chk("R7 ctrl held", ctrl_o, 8'h00); chk("R7 count held", count_o, 8'h00);
    n_int += int_rst_o; n_ext += !ext_rst_n_o;
    for (int i = 0; i < 600; i++) begin
      idle(); n_int += int_rst_o; n_ext += !ext_rst_n_o;
    end
    chk("R4 int length", n_int, 518); chk("R5 ext length", n_ext, 132);
    chk("R8 src stays 0", src_flag_o, 0);

    // R8 pin reset in the same cycle as a reset overflow
    wctl(8'h70); wcnt(8'hFF); drive(1, 1, 0, 0, 8'h00, 0);
    chk("R8 pin wins src", src_flag_o, 1); chk("R8 no int pulse", int_rst_o, 0);
    chk("R8 no ext pulse", ext_rst_n_o, 1);

    // R10 pin reset aborts a pulse
    wctl(8'h70); wcnt(8'hFF); tick(); repeat (10) idle();
    chk("R10 pulse running", int_rst_o, 1);
    drive(1, 0, 0, 0, 8'h00, 0);
    chk("R10 int ended", int_rst_o, 0); chk("R10 ext ended", ext_rst_n_o, 1);
    chk("R10 src", src_flag_o, 1);
    repeat (3) idle();
    summary();
  end
endmodule